// File: doc/BRIEF.md
# Accumulator Arithmetic Logic Unit

This block is a 32-bit arithmetic and logic unit built around a single accumulator register. The accumulator is always the first operand. The second operand comes from one of two sources: a full-width input that carries the scaled product, or a half-width input that carries the scaled data word. A mode input decides whether the half-width word is sign-extended or zero-filled.

Each enabled cycle performs one operation and writes the result back into the accumulator. The operations are addition, subtraction, AND, OR, XOR, single-bit test, one-position shifts, rotates through a carry flag, and a plain load. Carry, zero, negative and test flags follow the operations.

Either 16-bit half of the accumulator can be read out through a combinational left shifter for storage. The bits that enter that half come from the other half of the accumulator.

Top module: `acc_alu`

## Requirements
- R1: A synchronous reset sets acc to 0, carry to 0, zero to 1, neg to 0 and tflag to 0.
- R2: While en is low, a clock edge changes none of acc, carry, zero, neg or tflag, whatever op is.
- R3: When src_sel is 1, the second operand is prod_in unchanged. When src_sel is 0, the second operand is data_in extended to 32 bits.
- R4: When data_in is extended and sxm is 1, bits 31..16 copy data_in[15]. When sxm is 0, bits 31..16 are zero.
- R5: op 0 (add) stores acc + operand modulo 2^32 and sets carry to the carry out of bit 31.
- R6: op 1 (subtract) stores acc - operand modulo 2^32 and sets carry to 1 when no borrow occurs, that is when acc >= operand unsigned.
- R7: op 2, op 3 and op 4 store acc AND, OR and XOR the operand respectively, and leave carry unchanged.
- R8: op 5 (bit test) sets tflag to bit bit_sel of the operand and leaves acc and carry unchanged. No other op changes tflag.
- R9: op 6 shifts acc left by one, filling with 0. op 7 shifts acc right by one, filling with acc[31] when sxm is 1 and with 0 when sxm is 0. Both put the bit shifted out into carry.
- R10: op 8 rotates {carry, acc} left by one, so acc[0] takes the old carry and carry takes the old acc[31]. op 9 rotates right by one, so acc[31] takes the old carry and carry takes the old acc[0].
- R11: op 10 loads the operand into acc and leaves carry unchanged. ops 11 to 15 change neither acc nor carry nor tflag.
- R12: After every enabled operation, zero is 1 exactly when the new acc is 0, and neg equals bit 31 of the new acc.
- R13: store_out is combinational. Take acc rotated left by out_sh (0 to 7) positions; store_out is bits 31..16 of that value when out_hi is 1 and bits 15..0 when out_hi is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Write-back enable |
| op | input | 4 | Operation code |
| src_sel | input | 1 | Operand source: 1 selects prod_in, 0 selects data_in |
| prod_in | input | 32 | Full-width scaled product operand |
| data_in | input | 16 | Half-width scaled data operand |
| sxm | input | 1 | Sign-extension mode |
| bit_sel | input | 5 | Bit index used by the bit test |
| out_hi | input | 1 | Selects the upper (1) or lower (0) half for storage |
| out_sh | input | 3 | Left shift applied on the storage path |
| acc | output | 32 | Accumulator contents |
| store_out | output | 16 | Shifted half-word for storage |
| carry | output | 1 | Carry flag |
| zero | output | 1 | Zero flag |
| neg | output | 1 | Negative flag |
| tflag | output | 1 | Bit-test result flag |

## Verification
The bench builds the block with its default values: a 32-bit accumulator and a 3-bit storage shift. These defaults allow the full 0 to 7 range of the storage shift to be checked, including the positions where bits cross from one half into the other. The defaults also allow carry and borrow at the true 32-bit boundary, and sign extension from bit 15 into the upper half. Directed steps reach the wrap and boundary cases. A long pseudo-random run then mixes operations, sources, sxm values and enables, and every cycle is compared with a behavioural model.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W   = 32,
  parameter int OSW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [3:0]           op,
  input  logic                 src_sel,
  input  logic [W-1:0]         prod_in,
  input  logic [W/2-1:0]       data_in,
  input  logic                 sxm,
  input  logic [$clog2(W)-1:0] bit_sel,
  input  logic                 out_hi,
  input  logic [OSW-1:0]       out_sh,
  output logic [W-1:0]         acc,
  output logic [W/2-1:0]       store_out,
  output logic                 carry,
  output logic                 zero,
  output logic                 neg,
  output logic                 tflag
);
  localparam int H = W / 2;
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
                         OP_XOR = 4'd4, OP_BIT = 4'd5, OP_SHL = 4'd6, OP_SHR = 4'd7,
                         OP_ROL = 4'd8, OP_ROR = 4'd9, OP_LD = 4'd10;

  logic [W-1:0] ext, opnd, nxt;
  logic [W:0]   sum, dif;
  logic         nc, nt;
  logic [2*W-1:0] dbl;

  assign ext  = {{H{sxm & data_in[H-1]}}, data_in};
  assign opnd = src_sel ? prod_in : ext;
  assign sum  = {1'b0, acc} + {1'b0, opnd};
  assign dif  = {1'b0, acc} - {1'b0, opnd};

  always_comb begin
    nxt = acc;
    nc  = carry;
    nt  = tflag;
    case (op)
      OP_ADD: begin nxt = sum[W-1:0]; nc = sum[W]; end
      OP_SUB: begin nxt = dif[W-1:0]; nc = ~dif[W]; end
      OP_AND: nxt = acc & opnd;
      OP_OR:  nxt = acc | opnd;
      OP_XOR: nxt = acc ^ opnd;
      OP_BIT: nt = opnd[bit_sel];
      OP_SHL: begin nxt = {acc[W-2:0], 1'b0}; nc = acc[W-1]; end
      OP_SHR: begin nxt = {sxm & acc[W-1], acc[W-1:1]}; nc = acc[0]; end
      OP_ROL: begin nxt = {acc[W-2:0], carry}; nc = acc[W-1]; end
      OP_ROR: begin nxt = {carry, acc[W-1:1]}; nc = acc[0]; end
      OP_LD:  nxt = opnd;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      carry <= 1'b0;
      zero  <= 1'b1;
      neg   <= 1'b0;
      tflag <= 1'b0;
    end else if (en) begin
      acc   <= nxt;
      carry <= nc;
      tflag <= nt;
      zero  <= (nxt == '0);
      neg   <= nxt[W-1];
    end
  end

  assign dbl       = {acc, acc} << out_sh;
  assign store_out = out_hi ? dbl[2*W-1:W+H] : dbl[W+H-1:W];

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (acc == '0 && !carry && zero && !neg && !tflag));
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(acc) && $stable(carry) && $stable(tflag)));
  // R8
  bit_test_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_BIT) |=> ($stable(acc) && $stable(carry)));
  // R7
  logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> $stable(carry));
  // R12
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst) zero == (acc == '0));
  // R12
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst) neg == acc[W-1]);
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, en, src_sel, sxm, out_hi;
  logic [3:0] op;
  logic [31:0] prod_in;
  logic [15:0] data_in;
  logic [4:0] bit_sel;
  logic [2:0] out_sh;
  logic [31:0] acc;
  logic [15:0] store_out;
  logic carry, zero, neg, tflag;

  acc_alu dut (.clk(clk), .rst(rst), .en(en), .op(op), .src_sel(src_sel), .prod_in(prod_in),
               .data_in(data_in), .sxm(sxm), .bit_sel(bit_sel), .out_hi(out_hi), .out_sh(out_sh),
               .acc(acc), .store_out(store_out), .carry(carry), .zero(zero), .neg(neg), .tflag(tflag));

  int tests = 0, fails = 0;
  logic [31:0] m_acc;
  logic m_c, m_t;

  task automatic chk(string r, string f, longint a, longint e);
    tests++;
    if (a != e) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, f, a, e);
    end
  endtask

  function automatic logic [15:0] m_store(logic [31:0] v, logic hi, int s);
    logic [31:0] t = v;
    for (int i = 0; i < s; i++) t = {t[30:0], t[31]};
    return hi ? t[31:16] : t[15:0];
  endfunction

  task automatic compare(string r);
    chk(r, "acc", acc, m_acc);
    chk(r, "carry", carry, m_c);
    chk(r, "tflag", tflag, m_t);
    chk("R12", "zero", zero, (m_acc == 0));
    chk("R12", "neg", neg, m_acc[31]);
    chk("R13", "store_out", store_out, m_store(m_acc, out_hi, out_sh));
  endtask

  task automatic step(logic e, logic [3:0] o, logic s, logic [31:0] p, logic [15:0] d,
                      logic x, logic [4:0] b, string r);
    longint a, v;
    logic [31:0] w;
    en = e; op = o; src_sel = s; prod_in = p; data_in = d; sxm = x; bit_sel = b;
    if (s) v = p;
    else if (x && d[15]) v = 64'hFFFF0000 + d;
    else v = d;
    a = m_acc;
    if (e) begin
      case (o)
        0: begin w = 32'(a + v); m_c = ((a + v) > 64'hFFFFFFFF); m_acc = w; end
        1: begin m_c = (a >= v); m_acc = 32'(a - v); end
        2: m_acc = m_acc & v[31:0];
        3: m_acc = m_acc | v[31:0];
        4: m_acc = m_acc ^ v[31:0];
        5: m_t = v[b];
        6: begin m_c = m_acc[31]; m_acc = 32'(a * 2); end
        7: begin m_c = m_acc[0]; m_acc = 32'(a / 2) + ((x && a[31]) ? 32'h80000000 : 0); end
        8: begin w = 32'(a * 2) + m_c; m_c = a[31]; m_acc = w; end
        9: begin w = 32'(a / 2) + (m_c ? 32'h80000000 : 0); m_c = a[0]; m_acc = w; end
        10: m_acc = v[31:0];
        default: ;
      endcase
    end
    @(negedge clk);
    compare(r);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    rst = 1; en = 0; op = 0; src_sel = 0; prod_in = 0; data_in = 0; sxm = 0; bit_sel = 0;
    out_hi = 0; out_sh = 0;
    m_acc = 0; m_c = 0; m_t = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst = 0;
    step(1, 10, 1, 32'h80000000, 0, 0, 0, "R11 R3 load product");
    step(1, 10, 1, 32'hFFFFFFFF, 0, 0, 0, "R3 load all ones");
    step(1, 0, 0, 0, 16'h0001, 0, 0, "R5 add wraps to zero with carry");
    step(1, 1, 0, 0, 16'h0001, 0, 0, "R6 subtract borrow");
    step(1, 10, 0, 0, 16'h0005, 0, 0, "R11 load data");
    step(1, 1, 0, 0, 16'h0003, 0, 0, "R6 subtract no borrow");
    step(1, 10, 0, 0, 16'h8000, 1, 0, "R4 sign extended");
    step(1, 10, 0, 0, 16'h8000, 0, 0, "R4 zero filled");
    step(1, 0, 0, 0, 16'hFFFF, 1, 0, "R4 R5 add of sign-extended -1");
    step(1, 10, 1, 32'hF0F0A5A5, 0, 0, 0, "R3 load");
    step(1, 2, 1, 32'h0FF0FF00, 0, 0, 0, "R7 and");
    step(1, 3, 0, 0, 16'h000F, 0, 0, "R7 or");
    step(1, 4, 1, 32'hFFFFFFFF, 0, 0, 0, "R7 xor");
    step(1, 5, 1, 32'h80000000, 0, 0, 31, "R8 bit test high");
    step(1, 5, 0, 0, 16'h8000, 0, 20, "R8 bit test zero-filled");
    step(1, 5, 0, 0, 16'h8000, 1, 20, "R8 R4 bit test sign bit");
    step(1, 10, 1, 32'h80000001, 0, 0, 0, "R11 load");
    step(1, 7, 0, 0, 0, 1, 0, "R9 arithmetic right");
    step(1, 7, 0, 0, 0, 0, 0, "R9 logical right");
    step(1, 6, 0, 0, 0, 0, 0, "R9 left");
    step(1, 8, 0, 0, 0, 0, 0, "R10 rotate left");
    step(1, 9, 0, 0, 0, 0, 0, "R10 rotate right");
    step(1, 9, 0, 0, 0, 0, 0, "R10 rotate right again");
    step(0, 10, 1, 32'h12345678, 0, 0, 0, "R2 load while disabled");
    step(0, 5, 1, 32'hFFFFFFFF, 0, 0, 3, "R2 bit test while disabled");
    step(1, 12, 1, 32'h12345678, 0, 0, 0, "R11 unused op");
    step(1, 15, 1, 32'h12345678, 0, 0, 0, "R11 unused op");
    step(1, 10, 1, 32'h9ABC5678, 0, 0, 0, "R13 setup");
    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 8; s++) begin
        out_hi = h[0]; out_sh = 3'(s);
        #1;
        chk("R13", "store_out", store_out, m_store(m_acc, out_hi, s));
      end
    lf = 32'hACE1_2468;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      out_hi = lf[3]; out_sh = lf[9:7];
      step(lf[0] | lf[5], 4'(lf[14:11] % 11 + (lf[31] & lf[30] ? 11 : 0)), lf[1],
           {lf[15:0], lf[31:16]}, lf[23:8], lf[2], lf[29:25], "R5 R6 R9 R10 mixed");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule